// File: doc/BRIEF.md
# Real-Time-Clock Periodic Interrupt and Status Unit

This block is the interrupt and status side of a real-time-clock register file. It runs on a fast system clock. A one-cycle enable pulse stands for each edge of the 32.768 kHz reference. A divider chain driven by that enable makes a periodic tick at one of fifteen binary-weighted rates, and it can also drive a square-wave pin. Software reaches four byte-wide registers at indexes 10 to 13 through a simple read/write strobe port. Reads are combinational.

An external one-second strobe opens an update window. The update-in-progress bit rises at once and stays high for a fixed lead time and then for the update itself. When the window closes, the update-ended flag is raised. An external alarm-match strobe raises the alarm flag. The three event flags sit in a status register that clears when it is read. Each flag has its own enable. Any flag whose enable is set drives the summary bit and the active-low interrupt pin.

Top module: `rtc_irq_status`

## Requirements
- R1: After reset, index 10 reads 0x20, index 11 reads 0x00, index 12 reads 0x00 and `irq_n` is 1.
- R2: At index 10, bits 6:0 can be written and bit 7 (update in progress) is read-only. Index 11 can be written in full. Writes to indexes 12 and 13 have no effect.
- R3: The rate code is index 10 bits 3:0. Code n from 1 to 15 gives one periodic tick every 2^(n-1) reference enables. Code 0 gives no ticks.
- R4: Divider mode is index 10 bits 6:4. The chain runs only in mode 010. Modes 110 and 111 hold it cleared, and no tick is produced.
- R5: The square-wave enable is index 11 bit 3. When it is 1 and the rate code is not 0, `sqw_out` toggles on every tick. Otherwise `sqw_out` is driven 0.
- R6: An accepted `sec_strobe` makes bit 7 of index 10 read 1 from the next cycle on. It stays 1 for LEAD_TICKS + BUSY_TICKS reference enables (73 by default). When it falls, the update-ended flag is set in the same cycle.
- R7: While the stop-update bit (index 11 bit 7) is 1, `sec_strobe` is ignored and neither the update-in-progress bit nor the update-ended flag is set. Setting the stop-update bit during an open window closes the window without setting the flag.
- R8: The periodic flag (index 12 bit 6) is set by each tick. The alarm flag (index 12 bit 5) is set by `alarm_strobe`. The update-ended flag (index 12 bit 4) is set at the end of a window. Flags are set whether or not their enables are set.
- R9: Index 12 bit 7 is 1 when any flag is set together with its enable. The enables are index 11 bit 6 for the periodic flag, bit 5 for the alarm flag and bit 4 for the update-ended flag. `irq_n` is the inverse of index 12 bit 7.
- R10: A read of index 12 returns its current value and then clears the flags. A flag event in the same cycle as that read survives for the next read.
- R11: Index 13 always reads 0x80 (RAM and time valid).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | One-cycle pulse per 32.768 kHz reference edge |
| addr | input | ADDR_W | Register index |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe (side effects only; data is combinational) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| sec_strobe | input | 1 | One-second update request |
| alarm_strobe | input | 1 | Alarm-match event |
| irq_n | output | 1 | Active-low interrupt |
| sqw_out | output | 1 | Square-wave output |

## Verification
The bench measures the square-wave interval for codes ranging from the fastest to the slowest. An off-by-one in the rate decode therefore shows up as a halved or doubled period, and a slow code that wraps shows up as a wrong long period. It drives an alarm event in the same cycle as a status read. A design that lets the clear override the set loses that flag on the next read. It counts the exact width of the update window, which a design with an off-by-one lead or busy counter gets wrong. It sets the stop-update bit before a window and also in the middle of one, where a design that only gates new requests would still report a spurious update-ended flag.

// File: rtl/rtc_irq_pkg.sv
`timescale 1ns/1ps
package rtc_irq_pkg;
  // register indexes on the byte port
  localparam int IDX_CTRL_A = 10;
  localparam int IDX_CTRL_B = 11;
  localparam int IDX_FLAGS  = 12;
  localparam int IDX_VALID  = 13;

  // divider mode field
  localparam int          MODE_W      = 3;
  localparam logic [2:0]  DIV_RUN     = 3'b010;
  localparam logic [1:0]  DIV_HOLD_HI = 2'b11;

  // control B field positions
  localparam int B_STOP = 7;
  localparam int B_PIE  = 6;
  localparam int B_AIE  = 5;
  localparam int B_UIE  = 4;
  localparam int B_SQWE = 3;

  // internal flag vector order: [2]=periodic, [1]=alarm, [0]=update-ended
  localparam int FLAG_N = 3;

  localparam logic [7:0] VALID_WORD = 8'h80;

  typedef enum logic [1:0] {
    UW_IDLE = 2'd0,
    UW_LEAD = 2'd1,
    UW_BUSY = 2'd2
  } upd_state_t;
endpackage

// File: rtl/rtc_rate_div.sv
`timescale 1ns/1ps
module rtc_rate_div
  import rtc_irq_pkg::*;
#(
  parameter int RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_en,
  input  logic [MODE_W-1:0] mode,
  input  logic [RATE_W-1:0] rate,
  input  logic              sq_en,
  output logic              tick,
  output logic              sqw
);
  localparam int CNT_W = (1 << RATE_W) - 2;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W-1:0] mask;
  logic             sqw_q, sqw_d;
  logic             run, hold, rate_on;

  assign run     = (mode == DIV_RUN);
  assign hold    = (mode[MODE_W-1:MODE_W-2] == DIV_HOLD_HI);
  assign rate_on = (rate != '0);

  // bit gi of the mask takes part once the period exceeds 2^gi enables
  for (genvar gi = 0; gi < CNT_W; gi++) begin : g_mask
    assign mask[gi] = ({1'b0, rate} >= (RATE_W+1)'(gi + 2));
  end

  assign tick = ref_en && run && rate_on && ((cnt_q & mask) == mask);

  always_comb begin
    cnt_d = cnt_q;
    if (hold)             cnt_d = '0;
    else if (run && ref_en) cnt_d = cnt_q + CNT_W'(1);
  end

  always_comb begin
    sqw_d = 1'b0;
    if (sq_en && rate_on) sqw_d = tick ? ~sqw_q : sqw_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sqw_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sqw_q <= sqw_d;
    end
  end

  assign sqw = sqw_q;
endmodule

// File: rtl/rtc_upd_window.sv
`timescale 1ns/1ps
module rtc_upd_window
  import rtc_irq_pkg::*;
#(
  parameter int LEAD_TICKS = 8,
  parameter int BUSY_TICKS = 65
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_en,
  input  logic strobe,
  input  logic freeze,
  output logic uip,
  output logic done
);
  localparam int MAX_T = (LEAD_TICKS > BUSY_TICKS) ? LEAD_TICKS : BUSY_TICKS;
  localparam int CW    = $clog2(MAX_T + 1);

  upd_state_t     st_q, st_d;
  logic [CW-1:0]  cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    done  = 1'b0;
    if (freeze) begin
      st_d  = UW_IDLE;
      cnt_d = '0;
    end else begin
      case (st_q)
        UW_IDLE: if (strobe) begin
          st_d  = UW_LEAD;
          cnt_d = '0;
        end
        UW_LEAD: if (ref_en) begin
          if (cnt_q == CW'(LEAD_TICKS - 1)) begin
            st_d  = UW_BUSY;
            cnt_d = '0;
          end else cnt_d = cnt_q + CW'(1);
        end
        UW_BUSY: if (ref_en) begin
          if (cnt_q == CW'(BUSY_TICKS - 1)) begin
            st_d  = UW_IDLE;
            cnt_d = '0;
            done  = 1'b1;
          end else cnt_d = cnt_q + CW'(1);
        end
        default: begin
          st_d  = UW_IDLE;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= UW_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign uip = (st_q != UW_IDLE);
endmodule

// File: rtl/rtc_flag_reg.sv
`timescale 1ns/1ps
module rtc_flag_reg
  import rtc_irq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_N-1:0] set_ev,
  input  logic              clr,
  input  logic [FLAG_N-1:0] en,
  output logic [FLAG_N-1:0] flags,
  output logic              irqf
);
  logic [FLAG_N-1:0] flg_q, flg_d;

  // a same-cycle event wins over the read clear
  always_comb begin
    flg_d = clr ? '0 : flg_q;
    flg_d = flg_d | set_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flg_q <= '0;
    else        flg_q <= flg_d;
  end

  assign flags = flg_q;
  assign irqf  = |(flg_q & en);
endmodule

// File: rtl/rtc_irq_status.sv
`timescale 1ns/1ps
module rtc_irq_status
  import rtc_irq_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int RATE_W     = 4,
  parameter int LEAD_TICKS = 8,
  parameter int BUSY_TICKS = 65
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ref_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  input  logic              sec_strobe,
  input  logic              alarm_strobe,
  output logic              irq_n,
  output logic              sqw_out
);
  localparam int         A_W     = MODE_W + RATE_W;
  localparam logic [A_W-1:0] A_RESET = {DIV_RUN, {RATE_W{1'b0}}};

  logic [A_W-1:0]    reg_a_q, reg_a_d;
  logic [7:0]        reg_b_q, reg_b_d;
  logic              sel_a, sel_b, sel_c, sel_d;
  logic              tick, uip, upd_done, irqf;
  logic [FLAG_N-1:0] flags, flag_en, flag_set;

  assign sel_a = (addr == ADDR_W'(IDX_CTRL_A));
  assign sel_b = (addr == ADDR_W'(IDX_CTRL_B));
  assign sel_c = (addr == ADDR_W'(IDX_FLAGS));
  assign sel_d = (addr == ADDR_W'(IDX_VALID));

  always_comb begin
    reg_a_d = reg_a_q;
    reg_b_d = reg_b_q;
    if (wr_en && sel_a) reg_a_d = wdata[A_W-1:0];
    if (wr_en && sel_b) reg_b_d = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_a_q <= A_RESET;
      reg_b_q <= '0;
    end else begin
      reg_a_q <= reg_a_d;
      reg_b_q <= reg_b_d;
    end
  end

  rtc_rate_div #(.RATE_W(RATE_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .ref_en (ref_en),
    .mode   (reg_a_q[A_W-1:RATE_W]),
    .rate   (reg_a_q[RATE_W-1:0]),
    .sq_en  (reg_b_q[B_SQWE]),
    .tick   (tick),
    .sqw    (sqw_out)
  );

  rtc_upd_window #(.LEAD_TICKS(LEAD_TICKS), .BUSY_TICKS(BUSY_TICKS)) u_win (
    .clk    (clk),
    .rst_n  (rst_n),
    .ref_en (ref_en),
    .strobe (sec_strobe),
    .freeze (reg_b_q[B_STOP]),
    .uip    (uip),
    .done   (upd_done)
  );

  assign flag_set = {tick, alarm_strobe, upd_done};
  assign flag_en  = {reg_b_q[B_PIE], reg_b_q[B_AIE], reg_b_q[B_UIE]};

  rtc_flag_reg u_flags (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_ev (flag_set),
    .clr    (rd_en && sel_c),
    .en     (flag_en),
    .flags  (flags),
    .irqf   (irqf)
  );

  always_comb begin
    rdata = '0;
    if (sel_a)      rdata = {uip, reg_a_q};
    else if (sel_b) rdata = reg_b_q;
    else if (sel_c) rdata = {irqf, flags, 4'b0000};
    else if (sel_d) rdata = VALID_WORD;
  end

  assign irq_n = ~irqf;
endmodule

// File: rtl/rtc_irq_status_chk.sv
`timescale 1ns/1ps
module rtc_irq_status_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_en,
  input logic [7:0]        rdata,
  input logic              irq_n,
  input logic              sqw_out,
  input logic              alarm_strobe,
  input logic              uip,
  input logic [2:0]        flags,
  input logic [7:0]        reg_b,
  input logic [2:0]        mode,
  input logic              tick,
  input logic              upd_done
);
  logic rd_c;
  assign rd_c = rd_en && (addr == ADDR_W'(12));

  p_irq_pin_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(12)) |-> (irq_n == !rdata[7]));

  p_valid_word_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (addr == ADDR_W'(13)) |-> (rdata == 8'h80));

  p_no_tick_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[2:1] == 2'b11) |-> !tick);

  p_sqw_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_b[3] |=> !sqw_out);

  p_stop_blocks_uip_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_b[7] && !uip) |=> !uip);

  p_done_closes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_done |=> (!uip && flags[0]));

  p_alarm_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_strobe |=> flags[1]);

  p_read_clears_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_c && !alarm_strobe && !tick && !upd_done) |=> (flags == 3'b000));
endmodule

bind rtc_irq_status rtc_irq_status_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .addr         (addr),
  .rd_en        (rd_en),
  .rdata        (rdata),
  .irq_n        (irq_n),
  .sqw_out      (sqw_out),
  .alarm_strobe (alarm_strobe),
  .uip          (uip),
  .flags        (flags),
  .reg_b        (reg_b_q),
  .mode         (reg_a_q[6:4]),
  .tick         (tick),
  .upd_done     (upd_done)
);

// File: tb/rtc_irq_status_tb.sv
`timescale 1ns/1ps
module rtc_irq_status_tb;
  logic       clk, rst_n, ref_en, wr_en, rd_en, sec_strobe, alarm_strobe;
  logic [3:0] addr;
  logic [7:0] wdata, rdata;
  logic       irq_n, sqw_out;

  int errors = 0;
  int checks = 0;
  int cyc    = 0;

  // {rate code, expected interval between square-wave edges in enables}
  localparam logic [19:0] VEC [7] = '{
    {4'd1,  16'd1},    {4'd2, 16'd2},   {4'd3, 16'd4},  {4'd4, 16'd8},
    {4'd6,  16'd32},   {4'd9, 16'd256}, {4'd15, 16'd16384}
  };

  rtc_irq_status u_dut (
    .clk(clk), .rst_n(rst_n), .ref_en(ref_en), .addr(addr),
    .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata),
    .sec_strobe(sec_strobe), .alarm_strobe(alarm_strobe),
    .irq_n(irq_n), .sqw_out(sqw_out)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] v);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 v = rdata;
    @(posedge clk); #1;
    rd_en = 1'b0;
  endtask

  task automatic pulse_alarm();
    @(negedge clk); alarm_strobe = 1'b1;
    @(negedge clk); alarm_strobe = 1'b0;
  endtask

  task automatic pulse_sec();
    @(negedge clk); sec_strobe = 1'b1;
    @(negedge clk); sec_strobe = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic sqw_interval(output int per);
    logic s;
    int n;
    s = sqw_out; n = 0;
    while (sqw_out == s && n < 40000) begin @(negedge clk); n++; end
    s = sqw_out; n = 0;
    while (sqw_out == s && n < 40000) begin @(negedge clk); n++; end
    per = n;
  endtask

  initial begin
    logic [7:0] v;
    int per, hi, cnt;
    rst_n = 1'b0; ref_en = 1'b1; wr_en = 1'b0; rd_en = 1'b0;
    addr = 4'd0; wdata = 8'd0; sec_strobe = 1'b0; alarm_strobe = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;

    // R1 reset state
    rd(4'd10, v); chk("R1 reg A", v, 8'h20);
    rd(4'd11, v); chk("R1 reg B", v, 8'h00);
    rd(4'd12, v); chk("R1 reg C", v, 8'h00);
    chk("R1 irq_n", irq_n, 1);
    // R11
    rd(4'd13, v); chk("R11 reg D", v, 8'h80);

    // R2 writable fields, read-only bits, ignored writes
    wr(4'd10, 8'hA9); rd(4'd10, v); chk("R2 A bit7 read-only", v, 8'h29);
    wr(4'd11, 8'h5A); rd(4'd11, v); chk("R2 B full write", v, 8'h5A);
    wr(4'd10, 8'h20); wr(4'd11, 8'h00);
    rd(4'd12, v);
    wr(4'd12, 8'hF0); rd(4'd12, v); chk("R2 C write ignored", v, 8'h00);
    wr(4'd13, 8'h00); rd(4'd13, v); chk("R2 D write ignored", v, 8'h80);

    // R3/R5 rate table
    wr(4'd11, 8'h08);
    for (int k = 0; k < 7; k++) begin
      wr(4'd10, {4'h2, VEC[k][19:16]});
      sqw_interval(per);
      chk($sformatf("R3 R5 rate %0d period", VEC[k][19:16]), per, int'(VEC[k][15:0]));
    end

    // R5 rate 0 and square-wave disable hold the pin low
    wr(4'd10, 8'h20); wait_cyc(2);
    hi = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (sqw_out) hi++; end
    chk("R5 rate0 sqw low", hi, 0);
    wr(4'd11, 8'h00); wr(4'd10, 8'h21); wait_cyc(2);
    hi = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (sqw_out) hi++; end
    chk("R5 SQWE=0 sqw low", hi, 0);

    // R4 divider held in reset: no periodic flag
    wr(4'd10, 8'h61); rd(4'd12, v); wait_cyc(20);
    rd(4'd12, v); chk("R4 held divider no PF", v, 8'h00);
    wr(4'd10, 8'h21); wait_cyc(5);
    rd(4'd12, v); chk("R3 R8 running PF set", v, 8'h40);

    // R9 enables gate the summary bit
    wr(4'd11, 8'h40); wait_cyc(2);
    chk("R9 irq_n with PIE", irq_n, 0);
    rd(4'd12, v); chk("R9 C with PIE", v, 8'hC0);
    wr(4'd10, 8'h20); rd(4'd12, v);
    rd(4'd12, v); chk("R3 rate0 no PF", v, 8'h00);
    chk("R9 irq_n released", irq_n, 1);
    wr(4'd11, 8'h20); pulse_alarm();
    chk("R8 R9 irq_n alarm enabled", irq_n, 0);
    rd(4'd12, v); chk("R8 R9 C alarm enabled", v, 8'hA0);
    wr(4'd11, 8'h00); pulse_alarm();
    chk("R9 irq_n alarm disabled", irq_n, 1);
    rd(4'd12, v); chk("R8 C alarm disabled", v, 8'h20);

    // R10 event during the clearing read survives
    @(negedge clk);
    addr = 4'd12; rd_en = 1'b1; alarm_strobe = 1'b1;
    #1 v = rdata;
    @(negedge clk); rd_en = 1'b0; alarm_strobe = 1'b0;
    chk("R10 read before event", v, 8'h00);
    rd(4'd12, v); chk("R10 same-cycle event kept", v, 8'h20);
    rd(4'd12, v); chk("R10 cleared after read", v, 8'h00);

    // R6 update window width and end flag
    wr(4'd11, 8'h10);
    pulse_sec();
    addr = 4'd10; #1;
    chk("R6 UIP rises", rdata[7], 1);
    cnt = 0;
    while (rdata[7] && cnt < 500) begin @(negedge clk); #1; cnt++; end
    chk("R6 UIP high cycles", cnt, 73);
    chk("R6 irq_n at update end", irq_n, 0);
    rd(4'd12, v); chk("R6 UF at update end", v, 8'h90);

    // R7 stop-update ignores the strobe
    wr(4'd11, 8'h90); pulse_sec();
    hi = 0; addr = 4'd10;
    for (int i = 0; i < 100; i++) begin @(negedge clk); #1; if (rdata[7]) hi++; end
    chk("R7 UIP stays low", hi, 0);
    rd(4'd12, v); chk("R7 no UF when stopped", v, 8'h00);
    // R7 stop-update during an open window aborts it
    wr(4'd11, 8'h10); pulse_sec(); wait_cyc(10);
    wr(4'd11, 8'h90); wait_cyc(100);
    rd(4'd10, v); chk("R7 abort UIP low", v[7], 0);
    rd(4'd12, v); chk("R7 abort no UF", v, 8'h00);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule